// File: doc/BRIEF.md
# System-Management RAM Control Register File

This block is a small configuration register file inside a memory controller. It holds the controls that decide how system-management RAM is exposed. A base control byte carries the open, lock and global-enable flags. An extended control byte carries the high-window enable and the top-segment enable and size. A 16-bit size-query register lets firmware discover how large an extended top segment may be.

Software reaches the registers through a byte-addressed configuration port. The port has a word offset, two byte enables, write data and combinational read data. Each control byte has a write mask, so bits outside the mask keep their value.

Setting the lock flag empties both masks until reset. From then on the open, global-enable and lock flags and every extended field are frozen. The decoded flags go straight to the address router.

Top module: `smram_ctl_regs`

## Requirements
- R1: After reset the open, lock, global-enable, high-enable and segment-enable outputs are 0 and the segment size is 0. Offset 0x52 reads 0x3802. Offset 0x50 reads the parameter `XSZ`.
- R2: At offset 0x52 the low byte is the base control and the high byte is the extended control. In the low byte, bit 6 is open, bit 4 is lock and bit 3 is global enable. Bits 2:0 always read 3'b010, and bits 7 and 5 always read 0.
- R3: In the high byte at offset 0x52, bits 5:3 are cache-disable flags. They always read 3'b111 and ignore writes. Bit 6 reads 0.
- R4: Once lock is 1, writes change neither the global enable nor any extended field (high enable at high-byte bit 7, segment size at bits 2:1, segment enable at bit 0), until reset.
- R5: Once lock is 1, software cannot clear it. Only reset clears it.
- R6: The open flag reads 0 whenever lock is 1. This includes a single write that sets open and lock together.
- R7: With `XSZ` nonzero, a write to offset 0x50 whose merged 16-bit result is 0xFFFF stores `XSZ` instead. A later read returns `XSZ`.
- R8: Any other write to offset 0x50 updates only the bytes whose enable is set. Bit 0 of the enables selects the low byte and bit 1 selects the high byte.
- R9: With `XSZ` equal to 0, a write of 0xFFFF to offset 0x50 reads back as 0xFFFF.
- R10: Offsets other than 0x50 and 0x52 read 0, and writes to them change no register.
- R11: The decoded outputs show a write in the clock cycle that follows its acceptance edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe, sampled on the rising edge |
| cfg_off | input | 8 | Byte offset of the 16-bit word accessed |
| cfg_be | input | 2 | Byte enables for a write |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data for `cfg_off`, combinational |
| smm_open | output | 1 | Management RAM visible outside management mode |
| smm_lock | output | 1 | Controls locked until reset |
| smm_glb_en | output | 1 | Global management RAM enable |
| smm_high_en | output | 1 | High alias window enable |
| tseg_en | output | 1 | Top segment enable |
| tseg_sz | output | 2 | Top segment size code |

## Verification
The hardest case is a single write that sets open and lock together, and then attempts to undo the lock. The stimulus first programs the extended fields with the lock still clear. It then issues one write carrying open, lock and global enable. After that come full-word writes of all zeros and all ones, which must leave every frozen field in place.

The probe register is driven with both byte-wise and full-word writes into two instances, one with a nonzero size parameter and one with a zero size parameter. This separates the probe substitution from plain storage.

// File: rtl/smram_ctl_regs.sv
module smram_ctl_regs #(
  parameter int XSZ = 16,
  parameter logic [7:0] OFF_XSZ = 8'h50,
  parameter logic [7:0] OFF_CTL = 8'h52
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_off,
  input  logic [1:0]  cfg_be,
  input  logic [15:0] cfg_wdata,
  output logic [15:0] cfg_rdata,
  output logic        smm_open,
  output logic        smm_lock,
  output logic        smm_glb_en,
  output logic        smm_high_en,
  output logic        tseg_en,
  output logic [1:0]  tseg_sz
);
  localparam logic [15:0] XSZ_V  = 16'(XSZ);
  localparam logic [7:0]  SM_WM  = 8'h58;
  localparam logic [7:0]  EX_WM  = 8'h87;

  logic       r_open, r_lock, r_glb, r_high, r_ten;
  logic [1:0] r_tsz;
  logic [15:0] r_xsz;

  logic [7:0] sm_cur, ex_cur, sm_wm, ex_wm, sm_nxt, ex_nxt;
  logic [15:0] xsz_mrg;
  logic hit_x, hit_c;

  assign hit_x  = cfg_off == OFF_XSZ;
  assign hit_c  = cfg_off == OFF_CTL;
  assign sm_cur = {1'b0, r_open, 1'b0, r_lock, r_glb, 3'b010};
  assign ex_cur = {r_high, 1'b0, 3'b111, r_tsz, r_ten};
  assign sm_wm  = r_lock ? 8'h00 : SM_WM;
  assign ex_wm  = r_lock ? 8'h00 : EX_WM;
  assign sm_nxt = (sm_cur & ~sm_wm) | (cfg_wdata[7:0] & sm_wm);
  assign ex_nxt = (ex_cur & ~ex_wm) | (cfg_wdata[15:8] & ex_wm);
  assign xsz_mrg = {cfg_be[1] ? cfg_wdata[15:8] : r_xsz[15:8],
                    cfg_be[0] ? cfg_wdata[7:0]  : r_xsz[7:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_open <= 1'b0;
      r_lock <= 1'b0;
      r_glb  <= 1'b0;
      r_high <= 1'b0;
      r_ten  <= 1'b0;
      r_tsz  <= 2'b00;
      r_xsz  <= XSZ_V;
    end else if (cfg_wr) begin
      if (hit_c && cfg_be[0]) begin
        r_lock <= sm_nxt[4];
        r_glb  <= sm_nxt[3];
        r_open <= sm_nxt[6] & ~sm_nxt[4];
      end
      if (hit_c && cfg_be[1]) begin
        r_high <= ex_nxt[7];
        r_tsz  <= ex_nxt[2:1];
        r_ten  <= ex_nxt[0];
      end
      if (hit_x)
        r_xsz <= (XSZ != 0 && xsz_mrg == 16'hffff) ? XSZ_V : xsz_mrg;
    end
  end

  assign cfg_rdata   = hit_x ? r_xsz : hit_c ? {ex_cur, sm_cur} : 16'h0000;
  assign smm_open    = r_open;
  assign smm_lock    = r_lock;
  assign smm_glb_en  = r_glb;
  assign smm_high_en = r_high;
  assign tseg_en     = r_ten;
  assign tseg_sz     = r_tsz;
endmodule

module smram_ctl_regs_chk #(
  parameter logic [7:0] OFF_XSZ = 8'h50,
  parameter logic [7:0] OFF_CTL = 8'h52
) (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  cfg_off,
  input logic [15:0] cfg_rdata,
  input logic        smm_open,
  input logic        smm_lock,
  input logic        smm_glb_en,
  input logic        smm_high_en,
  input logic        tseg_en,
  input logic [1:0]  tseg_sz
);
  // R6
  open_lock_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(smm_open && smm_lock));
  // R5
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smm_lock |=> smm_lock);
  // R4
  frozen_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smm_lock |=> $stable({smm_glb_en, smm_high_en, tseg_en, tseg_sz}));
  // R3
  cache_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_off == OFF_CTL) |-> (cfg_rdata[13:11] == 3'b111));
  // R10
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_off != OFF_CTL && cfg_off != OFF_XSZ) |-> (cfg_rdata == 16'h0000));
endmodule

bind smram_ctl_regs smram_ctl_regs_chk #(.OFF_XSZ(OFF_XSZ), .OFF_CTL(OFF_CTL)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_off(cfg_off), .cfg_rdata(cfg_rdata),
  .smm_open(smm_open), .smm_lock(smm_lock), .smm_glb_en(smm_glb_en),
  .smm_high_en(smm_high_en), .tseg_en(tseg_en), .tseg_sz(tseg_sz));

// File: tb/test_smram_ctl_regs.sv
module test_smram_ctl_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [7:0] cfg_off = 8'h00;
  logic [1:0] cfg_be = 2'b00;
  logic [15:0] cfg_wdata = 16'h0000;
  logic [15:0] rdata, rdata_z;
  logic open_o, lock_o, glb_o, high_o, ten_o;
  logic [1:0] tsz_o;
  logic open_z, lock_z, glb_z, high_z, ten_z;
  logic [1:0] tsz_z;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  smram_ctl_regs #(.XSZ(16)) i_smram_ctl_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_off(cfg_off), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rdata), .smm_open(open_o), .smm_lock(lock_o),
    .smm_glb_en(glb_o), .smm_high_en(high_o), .tseg_en(ten_o), .tseg_sz(tsz_o));

  smram_ctl_regs #(.XSZ(0)) i_smram_ctl_regs_plain (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_off(cfg_off), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rdata_z), .smm_open(open_z), .smm_lock(lock_z),
    .smm_glb_en(glb_z), .smm_high_en(high_z), .tseg_en(ten_z), .tseg_sz(tsz_z));

  // behavioural reference model
  logic [7:0] m_sm = 8'h02;
  logic [7:0] m_ex = 8'h38;
  logic [15:0] m_x = 16'd16;
  logic [15:0] m_xz = 16'd0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sm = 8'h02; m_ex = 8'h38; m_x = 16'd16; m_xz = 16'd0;
    end else if (cfg_wr) begin
      logic old_lock;
      logic [15:0] mg;
      old_lock = m_sm[4];
      if (cfg_off == 8'h52 && !old_lock) begin
        if (cfg_be[0]) begin
          m_sm = 8'h02;
          m_sm[4] = cfg_wdata[4];
          m_sm[3] = cfg_wdata[3];
          m_sm[6] = cfg_wdata[6] && !cfg_wdata[4];
        end
        if (cfg_be[1]) begin
          m_ex = 8'h38;
          m_ex[7] = cfg_wdata[15];
          m_ex[2:1] = cfg_wdata[10:9];
          m_ex[0] = cfg_wdata[8];
        end
      end
      if (cfg_off == 8'h50) begin
        mg = m_x;
        if (cfg_be[0]) mg[7:0] = cfg_wdata[7:0];
        if (cfg_be[1]) mg[15:8] = cfg_wdata[15:8];
        m_x = (mg == 16'hffff) ? 16'd16 : mg;
        mg = m_xz;
        if (cfg_be[0]) mg[7:0] = cfg_wdata[7:0];
        if (cfg_be[1]) mg[15:8] = cfg_wdata[15:8];
        m_xz = mg;
      end
    end
  end

  function automatic logic [15:0] m_read(input logic [7:0] off, input logic [15:0] xv);
    if (off == 8'h50) return xv;
    if (off == 8'h52) return {m_ex, m_sm};
    return 16'h0000;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison with the model
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk({open_o, lock_o, glb_o, high_o, ten_o, tsz_o} ==
          {m_sm[6], m_sm[4], m_sm[3], m_ex[7], m_ex[0], m_ex[2:1]},
          "R11 outputs", 16'({open_o, lock_o, glb_o, high_o, ten_o, tsz_o}),
          16'({m_sm[6], m_sm[4], m_sm[3], m_ex[7], m_ex[0], m_ex[2:1]}));
      chk(rdata == m_read(cfg_off, m_x), "R2 rdata", rdata, m_read(cfg_off, m_x));
      chk(rdata_z == m_read(cfg_off, m_xz), "R9 rdata plain", rdata_z, m_read(cfg_off, m_xz));
    end
  end

  task automatic wr(input logic [7:0] off, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_off = off; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = 2'b00;
  endtask

  task automatic rd(input logic [7:0] off, input logic [15:0] exp, input logic [15:0] expz, input string tag);
    @(negedge clk);
    cfg_off = off;
    #3;
    chk(rdata == exp, tag, rdata, exp);
    chk(rdata_z == expz, tag, rdata_z, expz);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1
    rd(8'h52, 16'h3802, 16'h3802, "R1 ctl reset");
    rd(8'h50, 16'h0010, 16'h0000, "R1 size reset");
    chk({open_o, lock_o, glb_o, high_o, ten_o, tsz_o} == 7'd0, "R1 outputs", 16'(open_o), 16'h0);
    // R2 and R11
    wr(8'h52, 2'b01, 16'h00EF);
    rd(8'h52, 16'h384A, 16'h384A, "R2 base byte");
    chk(open_o && glb_o && !lock_o, "R11 open glb", 16'({open_o, glb_o, lock_o}), 16'h6);
    // R3
    wr(8'h52, 2'b10, 16'hFF00);
    rd(8'h52, 16'hBF4A, 16'hBF4A, "R3 ext all ones");
    wr(8'h52, 2'b10, 16'h0000);
    rd(8'h52, 16'h384A, 16'h384A, "R3 ext zero");
    // R10
    wr(8'h40, 2'b11, 16'hFFFF);
    rd(8'h40, 16'h0000, 16'h0000, "R10 unimpl read");
    rd(8'h52, 16'h384A, 16'h384A, "R10 ctl untouched");
    rd(8'h50, 16'h0010, 16'h0000, "R10 size untouched");
    // R8
    wr(8'h50, 2'b01, 16'h1234);
    rd(8'h50, 16'h0034, 16'h0034, "R8 low byte");
    wr(8'h50, 2'b10, 16'hAB00);
    rd(8'h50, 16'hAB34, 16'hAB34, "R8 high byte");
    // R7 and R9
    wr(8'h50, 2'b11, 16'hFFFF);
    rd(8'h50, 16'h0010, 16'hFFFF, "R7 R9 probe");
    // R6
    wr(8'h52, 2'b10, 16'h0500);
    wr(8'h52, 2'b01, 16'h0058);
    rd(8'h52, 16'h3D1A, 16'h3D1A, "R6 open rejected");
    chk(!open_o && lock_o && glb_o, "R6 outputs", 16'({open_o, lock_o, glb_o}), 16'h3);
    // R4 R5
    wr(8'h52, 2'b11, 16'h0000);
    rd(8'h52, 16'h3D1A, 16'h3D1A, "R5 lock kept");
    wr(8'h52, 2'b11, 16'hFFFF);
    rd(8'h52, 16'h3D1A, 16'h3D1A, "R4 fields frozen");
    chk(ten_o && tsz_o == 2'b10 && !high_o, "R4 outputs", 16'({high_o, tsz_o, ten_o}), 16'h5);
    // R1 again
    do_reset();
    rd(8'h52, 16'h3802, 16'h3802, "R1 lock cleared by reset");
    repeat (2) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule